// File: doc/BRIEF.md
# All-Channel Invalid Level Detector

This block watches a set of serial line receivers and reports, through an active-low flag, when every line has sat at an invalid level for a long time. Each channel supplies two digital flags from an external window slicer. The first flag says the line is beyond the valid threshold in either polarity, which means its magnitude is at least 2.7 V. The second flag says the line is in the indeterminate band between 0.3 V and 2.7 V. When both flags are low, the line is near ground, at 0.3 V or less. A disconnected cable whose inputs are pulled to ground therefore reads as invalid on every channel, and the flag eventually drops.

Qualification is asymmetric. The flag falls only after a long, unbroken all-invalid dwell, and it rises again after a short, unbroken run in which at least one channel is valid. A reading that is indeterminate but shows no valid channel pauses both dwell counts: it neither advances nor clears them. Power management logic typically uses the flag to decide when to shut the interface down. The block has no power-mode input, so it keeps working in every mode, and its output can be fed back to the power-control pins.

Both dwell lengths are parameters given in clock cycles. The slicer flags are asynchronous, so an optional synchronizer of SYNC_STAGES flops sits in front of the logic.

Top module: `rx_invalid_detector`

## Requirements
- R1: During reset and after it, invalid_n_o is 1. The synchronizer stages reset to "indeterminate", so no dwell count advances until real samples reach the logic.
- R2: Each channel is classified as follows. If its unsure flag is 1, the channel is indeterminate, whatever its ok flag says. Otherwise, ok = 1 means valid and ok = 0 means invalid.
- R3: invalid_n_o falls at the clock edge that processes the ASSERT_CYC-th consecutive sample in which every channel is invalid.
- R4: Any sample in which some channel is valid clears the all-invalid dwell, so a full ASSERT_CYC run is needed again.
- R5: A sample with no valid channel and at least one indeterminate channel holds both dwell counts and the output.
- R6: invalid_n_o rises at the edge that processes the RELEASE_CYC-th consecutive sample in which at least one channel is valid.
- R7: A sample in which all channels are invalid clears the release dwell.
- R8: A single valid channel is enough to release the flag, even while every other channel is invalid.
- R9: Each sample reaches the dwell logic after exactly SYNC_STAGES clock edges. The output register adds one more edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_ok_i | input | NUM_CH | Per-channel flag: line magnitude at or above the valid threshold |
| lvl_unsure_i | input | NUM_CH | Per-channel flag: line in the indeterminate band |
| invalid_n_o | output | 1 | Low when all lines have been invalid for the full dwell |

## Verification
The bench builds the block with four channels, an assert dwell of 12 cycles, a release dwell of 3 and two synchronizer stages. With these short dwells, a run can cross both thresholds many times in a few hundred cycles. It can also place single-cycle interruptions just before a threshold, and hit the cycle one short of each transition exactly. The two-stage synchronizer makes the latency term of every timing check non-zero. The dominance of the unsure flag is checked by showing that a channel with both flags set fails to clear an almost-complete dwell.

// File: rtl/lvldet_pkg.sv
package lvldet_pkg;

   typedef enum logic [1:0] {
      LVL_LOW    = 2'd0,
      LVL_GOOD   = 2'd1,
      LVL_UNSURE = 2'd2
   } lvl_class_e;

   // the band flag dominates the good flag
   function automatic lvl_class_e classify(input logic ok, input logic unsure);
      if (unsure)
         return LVL_UNSURE;
      else if (ok)
         return LVL_GOOD;
      else
         return LVL_LOW;
   endfunction

   function automatic int ctr_width(input int limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
   parameter int NUM_CH      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ok_i,
   input  logic [NUM_CH-1:0] unsure_i,
   output logic [NUM_CH-1:0] ok_o,
   output logic [NUM_CH-1:0] unsure_o
);

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign ok_o     = ok_i;
         assign unsure_o = unsure_i;
      end else begin : g_chain
         logic [NUM_CH-1:0] ok_q     [SYNC_STAGES];
         logic [NUM_CH-1:0] unsure_q [SYNC_STAGES];

         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  ok_q[s]     <= '0;
                  unsure_q[s] <= '1;
               end else if (s == 0) begin
                  ok_q[s]     <= ok_i;
                  unsure_q[s] <= unsure_i;
               end else begin
                  ok_q[s]     <= ok_q[(s > 0) ? s-1 : 0];
                  unsure_q[s] <= unsure_q[(s > 0) ? s-1 : 0];
               end
            end
         end

         assign ok_o     = ok_q[SYNC_STAGES-1];
         assign unsure_o = unsure_q[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lvl_merge.sv
module lvl_merge
   import lvldet_pkg::*;
#(
   parameter int NUM_CH = 5
) (
   input  logic [NUM_CH-1:0] ok_i,
   input  logic [NUM_CH-1:0] unsure_i,
   output logic              any_good_o,
   output logic              all_low_o
);

   logic [NUM_CH-1:0] is_good;
   logic [NUM_CH-1:0] is_low;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         lvl_class_e cls;
         assign cls        = classify(ok_i[c], unsure_i[c]);
         assign is_good[c] = (cls == LVL_GOOD);
         assign is_low[c]  = (cls == LVL_LOW);
      end
   endgenerate

   assign any_good_o = |is_good;
   assign all_low_o  = &is_low;

endmodule

// File: rtl/dwell_ctr.sv
module dwell_ctr
   import lvldet_pkg::*;
#(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic full_o
);

   localparam int W = ctr_width(LIMIT);
   localparam logic [W-1:0] TOP = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   assign full_o = (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr_i)
         cnt <= '0;
      else if (inc_i && !full_o)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/rx_invalid_detector.sv
module rx_invalid_detector #(
   parameter int NUM_CH      = 5,
   parameter int ASSERT_CYC  = 1500,
   parameter int RELEASE_CYC = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] lvl_ok_i,
   input  logic [NUM_CH-1:0] lvl_unsure_i,
   output logic              invalid_n_o
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (ASSERT_CYC < 1 || RELEASE_CYC < 1) begin : g_bad_dwell
         $error("dwell lengths must be at least 1 cycle");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [NUM_CH-1:0] ok_s;
   logic [NUM_CH-1:0] unsure_s;
   logic              any_good;
   logic              all_low;
   logic              fall_full;
   logic              rise_full;

   lvl_sync #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ok_i     (lvl_ok_i),
      .unsure_i (lvl_unsure_i),
      .ok_o     (ok_s),
      .unsure_o (unsure_s)
   );

   lvl_merge #(.NUM_CH(NUM_CH)) u_merge (
      .ok_i       (ok_s),
      .unsure_i   (unsure_s),
      .any_good_o (any_good),
      .all_low_o  (all_low)
   );

   // all-low dwell: cleared by any good channel, paused otherwise
   dwell_ctr #(.LIMIT(ASSERT_CYC)) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (any_good),
      .inc_i  (all_low),
      .full_o (fall_full)
   );

   // any-good dwell: cleared by an all-low sample, paused otherwise
   dwell_ctr #(.LIMIT(RELEASE_CYC)) u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (all_low),
      .inc_i  (any_good),
      .full_o (rise_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         invalid_n_o <= 1'b1;
      else if (all_low && fall_full)
         invalid_n_o <= 1'b0;
      else if (any_good && rise_full)
         invalid_n_o <= 1'b1;
   end

endmodule

// File: rtl/rx_invalid_detector_chk.sv
module rx_invalid_detector_chk (
   input logic clk,
   input logic rst_n,
   input logic any_good,
   input logic all_low,
   input logic invalid_n_o
);

   // R1
   reset_high_chk: assert property (@(posedge clk) !rst_n |=> (rst_n || invalid_n_o));

   // R2
   class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(any_good && all_low));

   // R3
   fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(invalid_n_o) |-> $past(all_low));

   // R4
   good_blocks_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_good |=> !$fell(invalid_n_o));

   // R5
   unsure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_good && !all_low) |=> $stable(invalid_n_o));

   // R6
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(invalid_n_o) |-> $past(any_good));

   // R7
   low_blocks_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_low |=> !$rose(invalid_n_o));

endmodule

bind rx_invalid_detector rx_invalid_detector_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .any_good    (any_good),
   .all_low     (all_low),
   .invalid_n_o (invalid_n_o)
);

// File: tb/test_rx_invalid_detector.sv
`timescale 1ns/1ps
module test_rx_invalid_detector;

   localparam int NC = 4;
   localparam int AC = 12;
   localparam int RC = 3;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] ok = '0;
   logic [NC-1:0] unsure = '0;
   logic          invalid_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rx_invalid_detector #(.NUM_CH(NC), .ASSERT_CYC(AC), .RELEASE_CYC(RC), .SYNC_STAGES(SS)) i_rx_invalid_detector (
      .clk          (clk),
      .rst_n        (rst_n),
      .lvl_ok_i     (ok),
      .lvl_unsure_i (unsure),
      .invalid_n_o  (invalid_n)
   );

   // behavioural reference model
   logic [2*NC-1:0] pipe[$];
   int  m_fall = 0;
   int  m_rise = 0;
   bit  m_out  = 1'b1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe.delete();
         m_fall = 0; m_rise = 0; m_out = 1'b1;
      end else begin
         pipe.push_back({unsure, ok});
         if (pipe.size() > SS) begin
            logic [2*NC-1:0] e;
            bit good, low;
            e = pipe.pop_front();
            good = 1'b0; low = 1'b1;
            for (int c = 0; c < NC; c++) begin
               if (e[NC+c]) low = 1'b0;
               else if (e[c]) begin good = 1'b1; low = 1'b0; end
            end
            if (good) begin
               m_fall = 0;
               if (m_rise + 1 >= RC) m_out = 1'b1;
               m_rise = (m_rise + 1 > RC) ? RC : m_rise + 1;
            end else if (low) begin
               m_rise = 0;
               if (m_fall + 1 >= AC) m_out = 1'b0;
               m_fall = (m_fall + 1 > AC) ? AC : m_fall + 1;
            end
         end
      end
   end

   // compare against the model every cycle (R3, R6)
   always @(negedge clk) begin
      if (!done) begin
         n_cmp++;
         if (invalid_n !== m_out) begin
            n_bad++;
            $display("FAIL model R3/R6 t=%0t actual=%b expected=%b", $time, invalid_n, m_out);
         end
      end
   end

   task automatic check(input string req, input logic exp);
      n_cmp++;
      if (invalid_n !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, invalid_n, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic [NC-1:0] o, input logic [NC-1:0] u);
      ok = o; unsure = u;
   endtask

   initial begin
      // R1: held in reset with every line low
      drive('0, '0);
      step(3);
      check("R1", 1'b1);
      rst_n = 1'b1;
      step(1);
      check("R1", 1'b1);
      // R3, R9: falls exactly AC+SS edges after the run starts
      step(AC + SS - 2);
      check("R9", 1'b1);
      step(1);
      check("R3", 1'b0);

      // R8, R6: one good channel releases after RC+SS edges
      drive(4'b0100, '0);
      step(RC + SS - 1);
      check("R6", 1'b0);
      step(1);
      check("R8", 1'b1);

      // R4: a single good sample restarts the all-low dwell
      drive('0, '0);
      step(8);
      check("R4", 1'b1);
      drive(4'b0010, '0);
      step(1);
      drive('0, '0);
      step(AC + SS - 1);
      check("R4", 1'b1);
      step(1);
      check("R4", 1'b0);

      // back to released
      drive('1, '0);
      step(RC + SS);
      check("R6", 1'b1);

      // R5, R2: unsure dominates ok and pauses the dwell
      drive('0, '0);
      step(5);
      drive(4'b0001, 4'b0001);
      step(4);
      drive('0, '0);
      step(AC - 5 + SS - 1);
      check("R2", 1'b1);
      step(1);
      check("R5", 1'b0);

      // R7, R5: release dwell cleared by low, paused by unsure
      drive(4'b1000, '0);
      step(2);
      drive('0, '0);
      step(1);
      drive(4'b1000, '0);
      step(2);
      drive('0, 4'b1000);
      step(1);
      check("R7", 1'b0);
      drive(4'b1000, '0);
      step(SS);
      check("R5", 1'b0);
      step(1);
      check("R7", 1'b1);

      step(5);
      check("R6", 1'b1);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule